// File: doc/BRIEF.md
# Accumulator Arithmetic and Flag Unit

This block is the arithmetic stage of a small 8-bit accumulator processor. Each transaction carries an operation code, the accumulator value, the index register value, an operand byte already fetched from memory, and the current condition flags. The block returns one result byte and the new flag set. The operations are:

- subtraction, with or without the incoming borrow;
- a right rotate through the carry flag, on the accumulator, the index register or the memory byte;
- the flag effect of storing the accumulator or the index register;
- copying the accumulator into the index register;
- forcing the carry flag.

Transactions enter on a valid/ready stream and leave on a second valid/ready stream through one output register. An input is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result appears on the output one cycle later. `in_ready` is high when the output register is empty, or when that register is being drained in the same cycle. This lets the unit take one transaction per cycle while the consumer keeps `out_ready` high. When the consumer holds `out_ready` low, the result is held and no new input is taken.

Flag vectors on `in_ccr` and `out_ccr` use bit 3 = half-carry H, bit 2 = negative N, bit 1 = zero Z, bit 0 = carry/borrow C. Unless a requirement says otherwise, N is bit 7 of the result byte and Z is set only when the result byte is zero. H is never changed by any operation.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (subtract) gives result = (A − M) mod 256. C is set exactly when M > A as unsigned numbers. N and Z follow the result, and H is kept.
- R2: Op code 1 (subtract with borrow) gives result = (A − M − C_in) mod 256. C is set exactly when M + C_in > A as unsigned numbers. N and Z follow the result, and H is kept.
- R3: Op codes 2, 3 and 4 rotate right the accumulator, the index register and the memory byte respectively. The result is {C_in, src[7:1]} and the new C is src[0].
- R4: For the rotates, N and Z are taken from the rotated result and H is kept.
- R5: Op codes 5 and 6 (store accumulator, store index) return the stored value (A or X) as the result. N and Z follow that value, and C and H are kept.
- R6: Op code 7 (accumulator to index transfer) returns A as the result and passes all four flags through unchanged.
- R7: Op code 8 (set carry) returns A as the result, sets C to 1, and leaves H, N and Z unchanged.
- R8: Op codes 9 to 15 are unused. They return A as the result and leave all flags unchanged.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_ccr` stay unchanged.
- R10: While reset is asserted, and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R11: An input accepted on one edge shows up on the output after that edge. Results leave in the order their inputs were accepted, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can accept the input this cycle |
| in_op | input | 4 | Operation code (see R1 to R8) |
| in_acc | input | 8 | Accumulator value |
| in_idx | input | 8 | Index register value |
| in_mem | input | 8 | Memory operand byte |
| in_ccr | input | 4 | Current flags {H,N,Z,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Result byte |
| out_ccr | output | 4 | Updated flags {H,N,Z,C} |

## Verification
Two things can happen in the same cycle: a held result is drained, and a new transaction is accepted into the register that is being freed. The bench sets `in_valid` and `out_ready` independently at random, so drain-with-refill, stall-with-offer and idle cycles all occur throughout a long run. Every accepted transaction is queued with an expected value computed by a bench function. Each drained result is compared with the head of that queue, so a refill that overwrites a result, or a result that appears twice, shows up as a mismatch or a count error. During stalls, the bench checks that the held outputs do not move from one cycle to the next.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_SUB  = 4'd0;
  localparam logic [OP_W-1:0] OP_SBC  = 4'd1;
  localparam logic [OP_W-1:0] OP_RORA = 4'd2;
  localparam logic [OP_W-1:0] OP_RORX = 4'd3;
  localparam logic [OP_W-1:0] OP_RORM = 4'd4;
  localparam logic [OP_W-1:0] OP_STA  = 4'd5;
  localparam logic [OP_W-1:0] OP_STX  = 4'd6;
  localparam logic [OP_W-1:0] OP_TAX  = 4'd7;
  localparam logic [OP_W-1:0] OP_SEC  = 4'd8;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic c;
  } ccr_t;

  typedef enum logic [1:0] {
    SRC_ACC = 2'd0,
    SRC_IDX = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    K_PASS  = 3'd0,
    K_SUB   = 3'd1,
    K_ROT   = 3'd2,
    K_STORE = 3'd3,
    K_SETC  = 3'd4
  } kind_e;

endpackage

// File: rtl/acc_alu_decode.sv
`timescale 1ns/1ps
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output src_e            src,
  output kind_e           kind,
  output logic            use_cin
);

  always_comb begin
    src     = SRC_ACC;
    kind    = K_PASS;
    use_cin = 1'b0;
    case (op)
      OP_SUB:  kind = K_SUB;
      OP_SBC: begin
        kind    = K_SUB;
        use_cin = 1'b1;
      end
      OP_RORA: kind = K_ROT;
      OP_RORX: begin
        kind = K_ROT;
        src  = SRC_IDX;
      end
      OP_RORM: begin
        kind = K_ROT;
        src  = SRC_MEM;
      end
      OP_STA:  kind = K_STORE;
      OP_STX: begin
        kind = K_STORE;
        src  = SRC_IDX;
      end
      OP_TAX:  kind = K_PASS;
      OP_SEC:  kind = K_SETC;
      default: kind = K_PASS;
    endcase
  end

endmodule

// File: rtl/acc_alu_sub.sv
`timescale 1ns/1ps
module acc_alu_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  input  logic         bin,
  output logic [W-1:0] diff,
  output logic         bout
);

  logic [W:0] chain;
  assign chain[0] = bin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic a_b, s_b;
      assign a_b = minuend[i];
      assign s_b = subtrahend[i];
      assign diff[i]    = a_b ^ s_b ^ chain[i];
      assign chain[i+1] = (~a_b & s_b) | (~(a_b ^ s_b) & chain[i]);
    end
  endgenerate

  assign bout = chain[W];

  // Borrow out equals an unsigned magnitude comparison (R1, R2)
  logic [W:0] need;
  always_comb begin
    need = {1'b0, subtrahend} + {{W{1'b0}}, bin};
    p_borrow_r2: assert (bout == (need > {1'b0, minuend}))
      else $error("borrow chain disagrees with comparison");
  end

endmodule

// File: rtl/acc_alu_rot.sv
`timescale 1ns/1ps
module acc_alu_rot #(
  parameter int W = 8
) (
  input  logic [W-1:0] src,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);

  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_shift
      assign res[i] = src[i+1];
    end
  endgenerate

  assign res[W-1] = cin;
  assign cout     = src[0];

  // Rotating left back through carry restores the source (R3)
  always_comb begin
    p_rot_inverse_r3: assert ({res[W-2:0], cout} == src && res[W-1] == cin)
      else $error("rotate not invertible");
  end

endmodule

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  kind_e        kind,
  input  logic [W-1:0] res,
  input  logic         sub_borrow,
  input  logic         rot_carry,
  input  ccr_t         fin,
  output ccr_t         fout
);

  logic res_neg, res_zero;
  assign res_neg  = res[W-1];
  assign res_zero = ~|res;

  always_comb begin
    fout = fin;
    case (kind)
      K_SUB: begin
        fout.n = res_neg;
        fout.z = res_zero;
        fout.c = sub_borrow;
      end
      K_ROT: begin
        fout.n = res_neg;
        fout.z = res_zero;
        fout.c = rot_carry;
      end
      K_STORE: begin
        fout.n = res_neg;
        fout.z = res_zero;
      end
      K_SETC:  fout.c = 1'b1;
      default: fout = fin;
    endcase
  end

  always_comb begin
    p_h_kept_r4: assert (fout.h == fin.h)
      else $error("half-carry modified");
    if (kind == K_SETC) begin
      p_setc_r7: assert (fout.c && fout.n == fin.n && fout.z == fin.z)
        else $error("set-carry flags wrong");
    end
    if (kind == K_PASS) begin
      p_pass_r6: assert (fout == fin)
        else $error("pass-through flags changed");
    end
    if (kind == K_STORE) begin
      p_store_c_r5: assert (fout.c == fin.c)
        else $error("store changed carry");
    end
  end

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_acc,
  input  logic [W-1:0]    in_idx,
  input  logic [W-1:0]    in_mem,
  input  logic [3:0]      in_ccr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic [3:0]      out_ccr
);

  src_e  src_sel;
  kind_e kind;
  logic  use_cin;
  ccr_t  fin, fnext;

  assign fin = ccr_t'(in_ccr);

  acc_alu_decode u_dec (
    .op      (in_op),
    .src     (src_sel),
    .kind    (kind),
    .use_cin (use_cin)
  );

  logic [W-1:0] src_val;
  always_comb begin
    case (src_sel)
      SRC_IDX: src_val = in_idx;
      SRC_MEM: src_val = in_mem;
      default: src_val = in_acc;
    endcase
  end

  logic [W-1:0] diff;
  logic         borrow;
  acc_alu_sub #(.W(W)) u_sub (
    .minuend    (in_acc),
    .subtrahend (in_mem),
    .bin        (use_cin & fin.c),
    .diff       (diff),
    .bout       (borrow)
  );

  logic [W-1:0] rot_res;
  logic         rot_c;
  acc_alu_rot #(.W(W)) u_rot (
    .src  (src_val),
    .cin  (fin.c),
    .res  (rot_res),
    .cout (rot_c)
  );

  logic [W-1:0] res_next;
  always_comb begin
    case (kind)
      K_SUB:   res_next = diff;
      K_ROT:   res_next = rot_res;
      K_STORE: res_next = src_val;
      default: res_next = in_acc;
    endcase
  end

  acc_alu_flags #(.W(W)) u_flg (
    .kind       (kind),
    .res        (res_next),
    .sub_borrow (borrow),
    .rot_carry  (rot_c),
    .fin        (fin),
    .fout       (fnext)
  );

  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ccr    <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_next;
      out_ccr    <= fnext;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ccr))
    else $error("held result moved");

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("accepted input produced no result");

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid)
    else $error("drained result duplicated");

endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [3:0] in_op, in_ccr, out_ccr;
  logic [7:0] in_acc, in_idx, in_mem, out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  acc_alu i_acc_alu (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_op (in_op), .in_acc (in_acc), .in_idx (in_idx), .in_mem (in_mem),
    .in_ccr (in_ccr),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_result (out_result), .out_ccr (out_ccr)
  );

  function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] x, input logic [7:0] m,
                                        input logic [3:0] f);
    logic h, n, z, c;
    logic [7:0] r, s;
    logic [8:0] need;
    {h, n, z, c} = f;
    r = a;
    case (op)
      4'd0, 4'd1: begin
        need = {1'b0, m} + ((op == 4'd1) ? {8'd0, c} : 9'd0);
        r = a - need[7:0];
        c = need > {1'b0, a};
        n = r[7]; z = (r == 8'd0);
      end
      4'd2, 4'd3, 4'd4: begin
        s = (op == 4'd2) ? a : (op == 4'd3) ? x : m;
        r = {c, s[7:1]};
        c = s[0];
        n = r[7]; z = (r == 8'd0);
      end
      4'd5, 4'd6: begin
        r = (op == 4'd5) ? a : x;
        n = r[7]; z = (r == 8'd0);
      end
      4'd8: c = 1'b1;
      default: r = a;
    endcase
    return {r, h, n, z, c};
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3/R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // directed corners: {op, a, x, m, flags}
  localparam int ND = 12;
  logic [35:0] dir_tab [ND];
  initial begin
    dir_tab[0]  = {4'd0, 8'h00, 8'h00, 8'h01, 4'b1000}; // R1 borrow, H kept
    dir_tab[1]  = {4'd0, 8'h42, 8'h00, 8'h42, 4'b0001}; // R1 zero, borrow clears
    dir_tab[2]  = {4'd1, 8'h00, 8'h00, 8'hFF, 4'b0001}; // R2 wrap to zero with borrow
    dir_tab[3]  = {4'd1, 8'h05, 8'h00, 8'h05, 4'b0001}; // R2 equal plus borrow
    dir_tab[4]  = {4'd1, 8'h80, 8'h00, 8'h7F, 4'b0000}; // R2 no borrow in
    dir_tab[5]  = {4'd2, 8'h01, 8'h00, 8'h00, 4'b0000}; // R3 R4 zero, carry out
    dir_tab[6]  = {4'd4, 8'h00, 8'h00, 8'h80, 4'b0001}; // R3 R4 carry into bit 7
    dir_tab[7]  = {4'd3, 8'hFF, 8'h55, 8'h00, 4'b1110}; // R3 index source
    dir_tab[8]  = {4'd6, 8'h12, 8'h00, 8'h00, 4'b1001}; // R5 zero store keeps C,H
    dir_tab[9]  = {4'd7, 8'h00, 8'h9A, 8'h00, 4'b1111}; // R6 flags untouched
    dir_tab[10] = {4'd8, 8'h3C, 8'h00, 8'h00, 4'b0110}; // R7 set carry
    dir_tab[11] = {4'd15, 8'hA5, 8'h00, 8'h00, 4'b0101}; // R8 unused code
  end

  logic [15:0] q[$];

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] head;
    logic [11:0] e;
    bit hold_pend, acc_pend;
    logic [7:0] h_res;
    logic [3:0] h_ccr;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_acc = '0; in_idx = '0; in_mem = '0; in_ccr = '0;
    hold_pend = 1'b0; acc_pend = 1'b0; h_res = '0; h_ccr = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R10", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", 32'(out_valid), 0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (hold_pend) begin
        check(out_valid && out_result == h_res && out_ccr == h_ccr, "R9",
              {19'd0, out_valid, out_result, out_ccr}, {19'd0, 1'b1, h_res, h_ccr});
      end
      if (acc_pend) check(out_valid == 1'b1, "R11", 32'(out_valid), 1);
      if (cyc < ND) begin
        {in_op, in_acc, in_idx, in_mem, in_ccr} = dir_tab[cyc];
        in_valid = 1'b1; out_ready = 1'b1;
      end else if (cyc < 3900) begin
        in_valid  = ($urandom % 4) != 0;
        out_ready = ($urandom % 5) < 3;
        in_op     = (($urandom % 8) == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
        in_acc    = 8'($urandom); in_idx = 8'($urandom);
        in_mem    = (($urandom % 6) == 0) ? in_acc : 8'($urandom);
        in_ccr    = 4'($urandom);
      end else begin
        in_valid = 1'b0; out_ready = 1'b1;
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R9", 32'(in_ready),
            32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R11", 32'(out_result), 32'hFFFF_FFFF);
        end else begin
          head = q.pop_front();
          check({out_result, out_ccr} == head[11:0], tag(head[15:12]),
                {20'd0, out_result, out_ccr}, {20'd0, head[11:0]});
        end
      end
      if (in_valid && in_ready) begin
        e = model(in_op, in_acc, in_idx, in_mem, in_ccr);
        q.push_back({in_op, e});
      end
      acc_pend  = in_valid && in_ready;
      hold_pend = out_valid && !out_ready;
      h_res = out_result; h_ccr = out_ccr;
    end
    @(negedge clk);
    check(q.size() == 0 && !out_valid, "R11", 32'(q.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule